// File: doc/BRIEF.md
# Four-Phase Bus Write Handshake

This block carries single-word writes from a master to a slave over a bus that has no shared clock. The master and the slave each run on their own clock, and the only timing agreement between them is a request/acknowledge pair that returns to zero. A user hands the master one command: an address and a data word. The master then puts the address, the data and a write direction on the bus. It waits a fixed number of its own cycles so that the slave can decode the address, and only then raises request.

The slave passes request through a two-flop synchroniser and checks whether the address falls inside its window of registers. On a hit it stores the data word and raises acknowledge. The master sees acknowledge through its own synchroniser and drops request. The slave then sees request low and drops acknowledge. Once the master sees acknowledge low, the write is complete and the master may accept a new command. An address outside the window is never acknowledged. In that case the master abandons the write after a bounded wait and reports a timeout. The slave's register contents can be read through a combinational read port on the slave side.

Top module: `bus_write_handshake`

## Requirements
- R1: After reset, request, acknowledge and direction are low, the master is ready for a command, and every slave register reads zero.
- R2: When a command is accepted, the address, the data and direction=1 appear on the bus on the next master cycle. Request rises exactly DECODE_CYC (default 3) master cycles after that cycle, and request is never high while direction is low.
- R3: On a request whose address lies in [SLAVE_BASE, SLAVE_BASE+REG_COUNT), the slave writes the data into register (address - SLAVE_BASE) and raises acknowledge. That register is then read back at rdIdx = address - SLAVE_BASE.
- R4: The handshake runs in a fixed order: request rises, acknowledge rises while request is high, request falls while acknowledge is high, and acknowledge falls only after request is low.
- R5: The master reports ready only when it is idle. A command presented while a transfer is running is ignored: it writes nothing and starts no transfer. No new request starts until acknowledge has fallen.
- R6: Address and data on the bus stay unchanged from the cycle they are driven until the transfer ends.
- R7: An address outside the slave window is never acknowledged and leaves all registers unchanged. Request then stays high for exactly TIMEOUT_CYC (default 64) master cycles. It falls in the same cycle as a one-cycle wrTimeout pulse, and ready returns in that cycle.
- R8: A successful write ends with a one-cycle wrDone pulse in the first cycle after the master has seen acknowledge low. In that cycle request, acknowledge and direction are low and ready is high. wrDone and wrTimeout are never high together.
- R9: Each side samples the incoming handshake line through two flops, so acknowledge rises more than two slave clock periods after request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mClk | input | 1 | Master clock |
| mRstN | input | 1 | Master reset, active low |
| cmdValid | input | 1 | Write command present |
| cmdAddr | input | ADDR_W | Command address |
| cmdData | input | DATA_W | Command data |
| cmdReady | output | 1 | Master idle and accepting a command |
| wrDone | output | 1 | One-cycle pulse: write acknowledged and handshake closed |
| wrTimeout | output | 1 | One-cycle pulse: write abandoned with no acknowledge |
| sClk | input | 1 | Slave clock |
| sRstN | input | 1 | Slave reset, active low |
| rdIdx | input | IDX_W | Slave register index for read-back |
| rdData | output | DATA_W | Contents of the selected slave register |
| busReq | output | 1 | Bus request line (master driven) |
| busAck | output | 1 | Bus acknowledge line (slave driven) |
| busDir | output | 1 | Bus direction, 1 = write in progress |
| busAddr | output | ADDR_W | Bus address lines |
| busData | output | DATA_W | Bus data lines |

## Verification
The hardest case to reach is a command that arrives in the middle of a running handshake. It must be shown to have no effect at all: no register write and no extra request. To reach it, the stimulus pulses cmdValid with a different in-window address and the inverted data word while request is high and acknowledge has not yet risen. Afterwards it reads back every register and watches direction and request stay low. The timeout path is reached by sweeping addresses on both edges of the window and at the extremes of the address space. For each of these the bench counts the cycles that request stays high.

// File: rtl/bus_write_pkg.sv
package bus_write_pkg;

  typedef enum logic [1:0] {
    M_IDLE,
    M_SETTLE,
    M_REQ,
    M_RELEASE
  } mstState_t;

  typedef enum logic {
    S_WAIT,
    S_HOLD
  } slvState_t;

  // strobes from master control into master datapath
  typedef struct packed {
    logic load;       // capture command, drive bus
    logic reqSet;     // raise request
    logic reqClr;     // drop request
    logic finishOk;   // transfer closed normally
    logic finishErr;  // transfer abandoned
  } mstStrobe_t;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/hs_master_ctrl.sv
module hs_master_ctrl
  import bus_write_pkg::*;
#(
  parameter int DECODE_CYC  = 3,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       ackSync,
  output mstStrobe_t strobe,
  output logic       cmdReady
);
  localparam int CNT_MAX = (DECODE_CYC > TIMEOUT_CYC) ? DECODE_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(DECODE_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  mstState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      M_IDLE: begin
        if (cmdValid) begin
          strobe.load = 1'b1;
          stateNext   = M_SETTLE;
          cntNext     = '0;
        end
      end
      M_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          strobe.reqSet = 1'b1;
          stateNext     = M_REQ;
          cntNext       = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      M_REQ: begin
        if (ackSync) begin
          strobe.reqClr = 1'b1;
          stateNext     = M_RELEASE;
        end else if (cnt == TIMEOUT_LAST) begin
          strobe.reqClr    = 1'b1;
          strobe.finishErr = 1'b1;
          stateNext        = M_IDLE;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      M_RELEASE: begin
        if (!ackSync) begin
          strobe.finishOk = 1'b1;
          stateNext       = M_IDLE;
        end
      end
      default: stateNext = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= M_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign cmdReady = (state == M_IDLE);
endmodule

// File: rtl/hs_master_path.sv
module hs_master_path
  import bus_write_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mstStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              busDir,
  output logic              busReq,
  output logic              wrDone,
  output logic              wrTimeout
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr   <= '0;
      busData   <= '0;
      busDir    <= 1'b0;
      busReq    <= 1'b0;
      wrDone    <= 1'b0;
      wrTimeout <= 1'b0;
    end else begin
      if (strobe.load) begin
        busAddr <= cmdAddr;
        busData <= cmdData;
        busDir  <= 1'b1;
      end else if (strobe.finishOk || strobe.finishErr) begin
        busDir <= 1'b0;
      end
      if (strobe.reqSet)      busReq <= 1'b1;
      else if (strobe.reqClr) busReq <= 1'b0;
      wrDone    <= strobe.finishOk;
      wrTimeout <= strobe.finishErr;
    end
  end
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import bus_write_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int REG_COUNT  = 4,
  parameter int SLAVE_BASE = 16,
  localparam int IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busDir,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              busAck
);
  localparam logic [ADDR_W:0] LO_BOUND = (ADDR_W + 1)'(SLAVE_BASE);
  localparam logic [ADDR_W:0] HI_BOUND = (ADDR_W + 1)'(SLAVE_BASE + REG_COUNT);

  logic              reqSync;
  slvState_t         state;
  logic              hit;
  logic [IDX_W-1:0]  offset;
  logic [DATA_W-1:0] regs [REG_COUNT];

  hs_sync2 reqSyncInst (
    .clk (clk),
    .rstN(rstN),
    .din (busReq),
    .dout(reqSync)
  );

  assign hit    = ({1'b0, busAddr} >= LO_BOUND) && ({1'b0, busAddr} < HI_BOUND);
  assign offset = IDX_W'(busAddr - ADDR_W'(SLAVE_BASE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_WAIT;
      busAck <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else begin
      unique case (state)
        S_WAIT: begin
          if (reqSync && busDir && hit) begin
            regs[offset] <= busData;
            busAck       <= 1'b1;
            state        <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (!reqSync) begin
            busAck <= 1'b0;
            state  <= S_WAIT;
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  assign rdData = regs[rdIdx];
endmodule

// File: rtl/bus_write_handshake.sv
module bus_write_handshake
  import bus_write_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REG_COUNT   = 4,
  parameter int SLAVE_BASE  = 16,
  parameter int DECODE_CYC  = 3,
  parameter int TIMEOUT_CYC = 64,
  localparam int IDX_W      = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic              mClk,
  input  logic              mRstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              cmdReady,
  output logic              wrDone,
  output logic              wrTimeout,
  input  logic              sClk,
  input  logic              sRstN,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              busReq,
  output logic              busAck,
  output logic              busDir,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData
);
  mstStrobe_t strobe;
  logic       ackSync;

  hs_sync2 ackSyncInst (
    .clk (mClk),
    .rstN(mRstN),
    .din (busAck),
    .dout(ackSync)
  );

  hs_master_ctrl #(
    .DECODE_CYC (DECODE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl (
    .clk     (mClk),
    .rstN    (mRstN),
    .cmdValid(cmdValid),
    .ackSync (ackSync),
    .strobe  (strobe),
    .cmdReady(cmdReady)
  );

  hs_master_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) path (
    .clk      (mClk),
    .rstN     (mRstN),
    .strobe   (strobe),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .busAddr  (busAddr),
    .busData  (busData),
    .busDir   (busDir),
    .busReq   (busReq),
    .wrDone   (wrDone),
    .wrTimeout(wrTimeout)
  );

  hs_slave #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT),
    .SLAVE_BASE(SLAVE_BASE)
  ) slave (
    .clk    (sClk),
    .rstN   (sRstN),
    .busReq (busReq),
    .busDir (busDir),
    .busAddr(busAddr),
    .busData(busData),
    .rdIdx  (rdIdx),
    .rdData (rdData),
    .busAck (busAck)
  );
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              mClk,
  input logic              mRstN,
  input logic              sClk,
  input logic              sRstN,
  input logic              busReq,
  input logic              busAck,
  input logic              busDir,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              cmdReady,
  input logic              wrDone,
  input logic              wrTimeout
);
  // R4
  ack_rise_needs_req_chk: assert property (@(posedge sClk) disable iff (!sRstN)
    $rose(busAck) |-> busReq);

  // R4
  ack_fall_after_release_chk: assert property (@(posedge sClk) disable iff (!sRstN)
    $fell(busAck) |-> !busReq);

  // R6
  bus_hold_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    (busDir && $past(busDir)) |-> ($stable(busAddr) && $stable(busData)));

  // R2
  req_needs_dir_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    busReq |-> busDir);

  // R5
  no_restart_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    $rose(busReq) |-> !busAck);

  // R5
  ready_idle_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    cmdReady |-> (!busReq && !busDir));

  // R8
  single_outcome_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    wrDone |-> (!wrTimeout && !busReq));
endmodule

bind bus_write_handshake hs_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk (
  .mClk     (mClk),
  .mRstN    (mRstN),
  .sClk     (sClk),
  .sRstN    (sRstN),
  .busReq   (busReq),
  .busAck   (busAck),
  .busDir   (busDir),
  .busAddr  (busAddr),
  .busData  (busData),
  .cmdReady (cmdReady),
  .wrDone   (wrDone),
  .wrTimeout(wrTimeout)
);

// File: tb/tb_bus_write_handshake.sv
`timescale 1ns/1ps
module tb_bus_write_handshake;
  localparam int  ADDR_W = 8;
  localparam int  DATA_W = 8;
  localparam int  REGS   = 4;
  localparam int  BASE   = 16;
  localparam int  DECODE = 3;
  localparam int  TOUT   = 64;
  localparam real M_PER  = 8.0;
  localparam real S_PER  = 11.0;

  logic              mClk = 1'b0;
  logic              sClk = 1'b0;
  logic              mRstN = 1'b0;
  logic              sRstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic [1:0]        rdIdx = '0;
  logic              cmdReady, wrDone, wrTimeout;
  logic [DATA_W-1:0] rdData;
  logic              busReq, busAck, busDir;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model [REGS];
  realtime tReq, tAck;
  bit ackSeen;

  always #(M_PER / 2) mClk = ~mClk;
  always #(S_PER / 2) sClk = ~sClk;

  always @(posedge busReq) tReq = $realtime;
  always @(posedge busAck) begin
    tAck = $realtime;
    ackSeen = 1'b1;
  end

  bus_write_handshake #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REGS),
    .SLAVE_BASE(BASE), .DECODE_CYC(DECODE), .TIMEOUT_CYC(TOUT)
  ) dut (
    .mClk(mClk), .mRstN(mRstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdReady(cmdReady), .wrDone(wrDone), .wrTimeout(wrTimeout),
    .sClk(sClk), .sRstN(sRstN), .rdIdx(rdIdx), .rdData(rdData),
    .busReq(busReq), .busAck(busAck), .busDir(busDir), .busAddr(busAddr),
    .busData(busData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < REGS; i++) begin
      @(negedge mClk);
      rdIdx = 2'(i);
      #1;
      chk(rdData == model[i], req, rdData, model[i]);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input bit hit, input bit poke);
    int n;
    @(negedge mClk);
    chk(cmdReady == 1'b1, "R5", cmdReady, 1);
    cmdAddr = a; cmdData = d; cmdValid = 1'b1;
    ackSeen = 1'b0;
    @(negedge mClk);
    cmdValid = 1'b0;
    chk(busDir == 1'b1 && busAddr == a && busData == d, "R2", busAddr, a);
    n = 0;
    while (!busReq && n < 100) begin
      n++;
      chk(busAddr == a && busData == d, "R6", busData, d);
      @(negedge mClk);
    end
    chk(n == DECODE, "R2", n, DECODE);
    if (hit) begin
      n = 0;
      while (!busAck && n < 100) begin
        if (poke && n == 1) begin
          cmdAddr = ADDR_W'(BASE + ((a - BASE + 1) % REGS));
          cmdData = ~d;
          cmdValid = 1'b1;
        end else begin
          cmdValid = 1'b0;
        end
        chk(cmdReady == 1'b0, "R5", cmdReady, 0);
        chk(busReq == 1'b1, "R4", busReq, 1);
        @(negedge mClk);
        n++;
      end
      cmdValid = 1'b0;
      chk(busAck == 1'b1, "R3", busAck, 1);
      chk(busReq == 1'b1, "R4", busReq, 1);
      chk((tAck - tReq) > 2.0 * S_PER, "R9", int'(tAck - tReq), int'(2.0 * S_PER));
      n = 0;
      while (busReq && n < 100) begin
        chk(busAddr == a && busData == d, "R6", busData, d);
        @(negedge mClk);
        n++;
      end
      chk(busAck == 1'b1, "R4", busAck, 1);
      n = 0;
      while (!wrDone && n < 100) begin
        chk(cmdReady == 1'b0 && busReq == 1'b0, "R5", cmdReady, 0);
        chk(busAddr == a && busData == d, "R6", busData, d);
        @(negedge mClk);
        n++;
      end
      chk(wrDone == 1'b1, "R8", wrDone, 1);
      chk(busAck == 1'b0 && busReq == 1'b0 && busDir == 1'b0, "R8", busAck, 0);
      chk(cmdReady == 1'b1 && wrTimeout == 1'b0, "R8", cmdReady, 1);
      @(negedge mClk);
      chk(wrDone == 1'b0, "R8", wrDone, 0);
    end else begin
      n = 0;
      while (busReq && n < 200) begin
        n++;
        @(negedge mClk);
      end
      chk(n == TOUT, "R7", n, TOUT);
      chk(wrTimeout == 1'b1 && wrDone == 1'b0, "R7", wrTimeout, 1);
      chk(cmdReady == 1'b1 && busDir == 1'b0, "R7", cmdReady, 1);
      chk(ackSeen == 1'b0, "R7", ackSeen, 0);
      @(negedge mClk);
      chk(wrTimeout == 1'b0, "R7", wrTimeout, 0);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge mClk);
      chk(busReq == 1'b0 && busDir == 1'b0, "R5", busReq, 0);
    end
  endtask

  initial begin
    #(M_PER * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < REGS; i++) model[i] = '0;
    repeat (5) @(negedge mClk);
    mRstN = 1'b1;
    sRstN = 1'b1;
    @(negedge mClk);
    // R1 reset state
    chk(busReq == 1'b0 && busAck == 1'b0 && busDir == 1'b0, "R1", busReq, 0);
    chk(cmdReady == 1'b1, "R1", cmdReady, 1);
    readAll("R1");

    // R3 sweep of every register with several data patterns
    for (int i = 0; i < REGS; i++) begin
      for (int p = 0; p < 3; p++) begin
        logic [DATA_W-1:0] d;
        d = DATA_W'(i * 53 + p * 91 + 7);
        doWrite(ADDR_W'(BASE + i), d, 1'b1, p == 1);
        model[i] = d;
        readAll("R3");
      end
    end

    // R7 addresses just outside and far from the window
    doWrite(ADDR_W'(BASE - 1), 8'hEE, 1'b0, 1'b0);
    readAll("R7");
    doWrite(ADDR_W'(BASE + REGS), 8'hDD, 1'b0, 1'b0);
    readAll("R7");
    doWrite(8'h00, 8'hCC, 1'b0, 1'b0);
    doWrite(8'hFF, 8'hBB, 1'b0, 1'b0);
    readAll("R7");

    // R3 window edges with extreme data after the timeouts
    doWrite(ADDR_W'(BASE), 8'hFF, 1'b1, 1'b0);
    model[0] = 8'hFF;
    doWrite(ADDR_W'(BASE + REGS - 1), 8'h00, 1'b1, 1'b1);
    model[REGS - 1] = 8'h00;
    readAll("R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule